// File: doc/BRIEF.md
# Serial Control and Status Port

This block is the digital slave end of a four-wire synchronous serial link. It sits between a host controller and an output-driver protection core. Each frame carries a 16-bit control word from host to device and returns a 16-bit status word from device to host at the same time. The block keeps the control word that drives the output stages and the protection logic. It also samples the status word that the protection logic presents.

All serial pins are sampled by a faster system clock. Edges are found in that clock's domain. The data-out pin is modelled as a value plus an enable, with no real tri-state driver.

A frame opens when the active-low select falls. At that moment the status word is captured, and its bit 0 (the temperature warning) is put on data-out at once. A host can therefore read that one bit by pulsing select and sending no clocks. Data-in is taken on falling serial-clock edges, bit 0 first. Data-out advances on rising edges.

The received word is committed when select rises, and only if exactly 16 falling edges were seen during the frame. Any other count leaves the control register as it was. When more than 16 clocks are sent, data-out repeats data-in delayed by 16 bits. This allows several devices to be chained on one select line.

Top module: `serial_ctrl_port`

## Requirements
- R1: `sdo_oe` is 0 while `sel_n` is high and 1 while `sel_n` is low, after the input synchroniser delay.
- R2: On the falling edge of `sel_n`, `status_word` is captured, and its bit 0 appears on `sdo` before any serial-clock edge.
- R3: `sdi` is sampled on each falling `sclk` edge while selected. The first sampled bit lands in bit 0 of the received word and the sixteenth in bit 15.
- R4: `sdo` changes only on rising `sclk` edges that follow at least one falling edge of the current frame. Before falling edge k (counted from 0), `sdo` shows status bit k for k from 0 to 15.
- R5: A frame with fewer than 16 falling edges, including none at all, leaves `ctrl_word` unchanged.
- R6: A frame with more than 16 falling edges leaves `ctrl_word` unchanged. Before falling edge k, for k of 16 or more, `sdo` shows the `sdi` bit sampled at falling edge k-16.
- R7: After reset, `ctrl_word` is 16'hE000: bit 15 (software run enable, 0 = standby), bit 14 (long short-circuit delay) and bit 13 (open-load check off, active low) are 1, and all other bits are 0.
- R8: `ctrl_word` changes only when `sel_n` rises at the end of a frame with exactly 16 falling edges. It is then loaded with the received word and keeps its bit positions: bit 0 is status clear, bits 1 to 12 are the low-side and high-side enables of channels 1 to 6 in alternation, and bits 13 to 15 are as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sclk` |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock, idle low |
| sdi | input | 1 | Serial data in, LSB first |
| sdo | output | 1 | Serial data out value |
| sdo_oe | output | 1 | Serial data out enable (0 = high impedance) |
| status_word | input | 16 | Status word from the protection logic |
| ctrl_word | output | 16 | Committed control word |

## Verification
The bench sends a walking-one control word in every bit position, paired with a walking-zero status word. This separates each received bit position from each returned status position and exposes any swap or shift by one.

Frames of 0, 1, 8, 15, 17, 20, 31 and 32 clocks then check the commit rule on both sides of sixteen. The zero-clock frame is the warning-bit-only read. The long frames also test the 16-bit pass-through delay and the counter saturation.

Each frame starts with a rising clock before the first falling edge. This tells apart a design that shifts on any rising edge from one that waits for the first sample.

// File: rtl/serial_ctrl_port.sv
module serial_ctrl_port #(
  parameter int W = 16,
  parameter int SYNC = 2,
  parameter logic [W-1:0] CTRL_INIT = 16'hE000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel_n,
  input  logic         sclk,
  input  logic         sdi,
  output logic         sdo,
  output logic         sdo_oe,
  input  logic [W-1:0] status_word,
  output logic [W-1:0] ctrl_word
);
  localparam int CW = $clog2(W) + 1;
  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [CW-1:0] CNT_FULL = CW'(W);

  logic [SYNC-1:0] cs_q, ck_q, di_q;
  logic            cs_d, ck_d;
  logic [W-1:0]    rx, tx;
  logic [CW-1:0]   cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q <= '1;
      ck_q <= '0;
      di_q <= '0;
      cs_d <= 1'b1;
      ck_d <= 1'b0;
    end else begin
      cs_q <= {cs_q[SYNC-2:0], sel_n};
      ck_q <= {ck_q[SYNC-2:0], sclk};
      di_q <= {di_q[SYNC-2:0], sdi};
      cs_d <= cs_q[SYNC-1];
      ck_d <= ck_q[SYNC-1];
    end

  wire cs_s    = cs_q[SYNC-1];
  wire ck_s    = ck_q[SYNC-1];
  wire cs_fall = cs_d & ~cs_s;
  wire cs_rise = ~cs_d & cs_s;
  wire ck_fall = ck_d & ~ck_s & ~cs_s;
  wire ck_rise = ~ck_d & ck_s & ~cs_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx  <= '0;
      tx  <= '0;
      cnt <= '0;
    end else if (cs_fall) begin
      tx  <= status_word;
      cnt <= '0;
    end else begin
      if (ck_fall) begin
        rx <= {di_q[SYNC-1], rx[W-1:1]};
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
      if (ck_rise && cnt != '0)
        tx <= {rx[W-1], tx[W-1:1]};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctrl_word <= CTRL_INIT;
    else if (cs_rise && cnt == CNT_FULL) ctrl_word <= rx;

  assign sdo    = tx[0];
  assign sdo_oe = ~cs_s;
endmodule

// File: rtl/serial_ctrl_port_chk.sv
module serial_ctrl_port_chk #(
  parameter int W = 16,
  parameter logic [W-1:0] CTRL_INIT = 16'hE000
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sel_n,
  input logic         sclk,
  input logic         sdo,
  input logic         sdo_oe,
  input logic [W-1:0] ctrl_word
);
  // R1
  a_r1_oe_off_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n && $past(sel_n) && $past(sel_n, 2)) |-> !sdo_oe);

  // R1
  a_r1_oe_on_when_selected: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !$past(sel_n) && !$past(sel_n, 2)) |-> sdo_oe);

  // R4
  a_r4_sdo_quiet_without_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk == $past(sclk) && sclk == $past(sclk, 2) && sclk == $past(sclk, 3) &&
     sclk == $past(sclk, 4) && sel_n == $past(sel_n) && sel_n == $past(sel_n, 2) &&
     sel_n == $past(sel_n, 3) && sel_n == $past(sel_n, 4)) |-> $stable(sdo));

  // R8
  a_r8_ctrl_moves_only_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_word) |-> !sdo_oe);

  // R7
  a_r7_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> ctrl_word == CTRL_INIT);
endmodule

bind serial_ctrl_port serial_ctrl_port_chk #(.W(W), .CTRL_INIT(CTRL_INIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk),
  .sdo(sdo), .sdo_oe(sdo_oe), .ctrl_word(ctrl_word)
);

// File: tb/serial_ctrl_port_bench.sv
module serial_ctrl_port_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe;
  logic [15:0] status_word = '0;
  logic [15:0] ctrl_word;
  logic [15:0] model = 16'hE000;
  int applied = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  serial_ctrl_port u_serial_ctrl_port (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .status_word(status_word), .ctrl_word(ctrl_word)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Frame with n falling edges; din bit i is sent at falling edge i.
  task automatic frame(input logic [31:0] din, input int n, input logic [15:0] st);
    status_word = st;
    sel_n = 1'b0;
    wait_n(6);
    chk(sdo_oe === 1'b1, "R1 oe on", {31'd0, sdo_oe}, 32'd1);
    chk(sdo === st[0], "R2 bit0 at select", {31'd0, sdo}, {31'd0, st[0]});
    status_word = ~st;
    for (int i = 0; i < n; i++) begin
      sdi = din[i];
      wait_n(8);
      sclk = 1'b1;
      wait_n(8);
      if (i < 16)
        chk(sdo === st[i], "R4 status bit order", {31'd0, sdo}, {31'd0, st[i]});
      else
        chk(sdo === din[i-16], "R6 pass-through delay", {31'd0, sdo}, {31'd0, din[i-16]});
      chk(ctrl_word === model, "R8 stable mid-frame", {16'd0, ctrl_word}, {16'd0, model});
      sclk = 1'b0;
      wait_n(8);
    end
    sel_n = 1'b1;
    wait_n(6);
    chk(sdo_oe === 1'b0, "R1 oe off", {31'd0, sdo_oe}, 32'd0);
    if (n == 16) begin
      model = din[15:0];
      chk(ctrl_word === model, "R3 R8 commit", {16'd0, ctrl_word}, {16'd0, model});
    end else if (n < 16)
      chk(ctrl_word === model, "R5 short frame ignored", {16'd0, ctrl_word}, {16'd0, model});
    else
      chk(ctrl_word === model, "R6 long frame ignored", {16'd0, ctrl_word}, {16'd0, model});
    wait_n(4);
  endtask

  initial begin
    wait_n(4);
    chk(sdo_oe === 1'b0, "R1 oe in reset", {31'd0, sdo_oe}, 32'd0);
    rst_n = 1'b1;
    wait_n(2);
    chk(ctrl_word === 16'hE000, "R7 reset value", {16'd0, ctrl_word}, 32'h0000E000);
    frame(32'h0000_1234, 0, 16'h0001);
    frame(32'h0000_1234, 0, 16'h0000);
    for (int b = 0; b < 16; b++)
      frame(32'hA5C3_0000 | (32'd1 << b), 16, ~(16'd1 << b));
    frame(32'h0000_E000, 16, 16'h8001);
    foreach (model[k]) ;
    frame(32'h0000_5A5A, 1, 16'h1111);
    frame(32'h0000_5A5A, 8, 16'h2222);
    frame(32'h0000_5A5A, 15, 16'h3333);
    frame(32'h1234_5A5A, 17, 16'h4444);
    frame(32'hCAFE_F00D, 20, 16'h5555);
    frame(32'hDEAD_BEEF, 31, 16'h6666);
    frame(32'h8765_4321, 32, 16'h7777);
    frame(32'h0000_FFFF, 16, 16'hFFFF);
    frame(32'h0000_0000, 16, 16'h0000);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      applied++;
      bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end
endmodule